// File: doc/BRIEF.md
# Fractional Modulated Baud Generator

This block turns an arbitrary source clock into the timing enables a UART needs. The nominal divide factor is the source frequency over the baud rate. It is rarely an integer, so the block combines an integer prescaler with modulation. Modulation lengthens chosen periods by one source clock, so that over several periods the average comes close to the fractional ratio. Each enable is a single-cycle pulse in the source clock domain.

There are two modes. In low-frequency mode there is one count per bit. The integer divider is set to INT(N), and a 3-bit setting round(frac(N)×8) picks which bits of a character get one extra clock. In oversampling mode the divider is INT(N/16) and the block produces a 16x sample enable. A 4-bit setting round(frac(N/16)×16) stretches chosen sample periods, and the same 3-bit per-bit pattern may add one clock at the end of a bit. The block also marks three points around mid-bit, where a receiver takes a majority vote. A pulse on the start input, given when a start bit is detected, restarts the bit timing and both patterns.

Top module: `frac_baud_gen`

## Requirements
- R1: While `hold` is high, all outputs are low, the timing restarts at bit 0, and the settings inputs are captured. While `hold` is low, changes on `ovs_mode`, `div_val`, `bit_mod` and `smp_mod` have no effect.
- R2: In low-frequency mode, bit b lasts D + E8(s, b mod 8) source clocks, and `bit_tick` is high in its last cycle. D is the captured divider (raised to 3, see R5). s is `bit_mod`. E8(s,i) = floor((i+1)s/8) − floor(i·s/8).
- R3: A per-bit setting of 4 lengthens bits 1, 3, 5 and 7 of each group of eight, and leaves bits 0, 2, 4 and 6 unchanged.
- R4: When `start_sync` is high at a clock edge, the next cycle is the first cycle of bit 0, with both patterns at index 0. The first `bit_tick` comes L0 cycles later, counting that cycle as 1.
- R5: In low-frequency mode, a divider below 3 acts as 3.
- R6: In low-frequency mode, with bit length L and cycle position p counted from 0, `vote[0]`, `vote[1]` and `vote[2]` are high at p = floor(L/2)−1, floor(L/2) and floor(L/2)+1. At most one vote bit is high in any cycle.
- R7: In oversampling mode with divider D ≥ 2, sample period j (0..15) of every bit lasts D + E16(t, j) clocks. t is `smp_mod`, and E16(t,j) = floor((j+1)t/16) − floor(j·t/16). `smp_tick` is high in the last cycle of each sample period.
- R8: In oversampling mode, a bit is 16 sample periods, plus one extra clock when E8(s, b mod 8) is 1. `bit_tick` is high in the bit's last cycle, and `smp_tick` is low in the extra clock.
- R9: In oversampling mode with divider 0 or 1, each sample period is one clock and `smp_mod` is ignored.
- R10: In oversampling mode, `vote[0..2]` coincide with the `smp_tick` of sample periods 6, 7 and 8.
- R11: In low-frequency mode, `smp_tick` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Software reset; settings are captured while high |
| ovs_mode | input | 1 | 1 = oversampling mode, 0 = low-frequency mode |
| div_val | input | DIV_W | Integer prescaler value |
| bit_mod | input | 3 | Per-bit modulation setting |
| smp_mod | input | 4 | Per-sample modulation setting |
| start_sync | input | 1 | Restart pulse at a detected start bit |
| bit_tick | output | 1 | Last cycle of each bit |
| smp_tick | output | 1 | Last cycle of each 16x sample period |
| vote | output | 3 | Majority-vote sample strobes |

## Verification
The bench builds the block with the default 16-bit divider. It programs small divider values so that nine whole bits fit in short runs. This reaches the wrap of the 8-step pattern, the clamp to 3 in low-frequency mode, and the divider-0/1 bypass in oversampling mode. It also covers full and empty 16-step patterns, the one-clock tail after the sixteenth sample, and a restart pulse that lands partway through a character. One low-frequency setting near 216 exercises long bits, where the vote window sits far from the bit edges.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             ovs_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic [2:0]       bit_mod,
  input  logic [3:0]       smp_mod,
  input  logic             start_sync,
  output logic             bit_tick,
  output logic             smp_tick,
  output logic [2:0]       vote
);
  localparam int CNT_W   = DIV_W + 1;
  localparam int SMP_MID = 7;

  function automatic logic step8(input logic [2:0] s, input logic [2:0] i);
    logic [6:0] a, b;
    a = (7'(i) + 7'd1) * 7'(s);
    b = 7'(i) * 7'(s);
    return a[6:3] != b[6:3];
  endfunction

  function automatic logic step16(input logic [3:0] s, input logic [3:0] j);
    logic [8:0] a, b;
    a = (9'(j) + 9'd1) * 9'(s);
    b = 9'(j) * 9'(s);
    return a[8:4] != b[8:4];
  endfunction

  logic             c_os;
  logic [DIV_W-1:0] c_div;
  logic [2:0]       c_bm;
  logic [3:0]       c_sm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_os  <= 1'b0;
      c_div <= '0;
      c_bm  <= '0;
      c_sm  <= '0;
    end else if (hold) begin
      c_os  <= ovs_mode;
      c_div <= div_val;
      c_bm  <= bit_mod;
      c_sm  <= smp_mod;
    end

  logic [CNT_W-1:0] cnt;
  logic [3:0]       sidx;
  logic [2:0]       bidx;
  logic             tail;

  logic             bm_on, sm_on, bypass;
  logic [CNT_W-1:0] lf_len, per, mid;
  logic             lf_end, os_smp, os_end;

  assign bm_on  = step8(c_bm, bidx);
  assign sm_on  = step16(c_sm, sidx);
  assign bypass = c_div < DIV_W'(2);
  assign lf_len = ((c_div < DIV_W'(3)) ? CNT_W'(3) : CNT_W'(c_div)) + CNT_W'(bm_on);
  assign per    = bypass ? CNT_W'(1) : CNT_W'(c_div) + CNT_W'(sm_on);
  assign mid    = lf_len >> 1;
  assign lf_end = cnt == lf_len - CNT_W'(1);
  assign os_smp = !tail && (cnt == per - CNT_W'(1));
  assign os_end = tail || (os_smp && sidx == 4'd15 && !bm_on);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      sidx <= '0;
      bidx <= '0;
      tail <= 1'b0;
    end else if (hold || start_sync) begin
      cnt  <= '0;
      sidx <= '0;
      bidx <= '0;
      tail <= 1'b0;
    end else if (!c_os) begin
      if (lf_end) begin
        cnt  <= '0;
        bidx <= bidx + 3'd1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else if (tail) begin
      tail <= 1'b0;
      bidx <= bidx + 3'd1;
    end else if (os_smp) begin
      cnt  <= '0;
      sidx <= sidx + 4'd1;
      if (sidx == 4'd15) begin
        if (bm_on) tail <= 1'b1;
        else       bidx <= bidx + 3'd1;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end

  assign bit_tick = !hold && (c_os ? os_end : lf_end);
  assign smp_tick = !hold && c_os && os_smp;

  always_comb
    for (int k = 0; k < 3; k++)
      if (hold)
        vote[k] = 1'b0;
      else if (c_os)
        vote[k] = os_smp && (sidx == 4'(SMP_MID - 1 + k));
      else
        vote[k] = cnt == mid + CNT_W'(k) - CNT_W'(1);

  p_vote_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n || hold)
    $onehot0(vote));

  p_vote_order_r6: assert property (@(posedge clk) disable iff (!rst_n || hold)
    !c_os && vote[0] && !start_sync |=> vote[1]);

  p_min_bit_r5: assert property (@(posedge clk) disable iff (!rst_n || hold)
    !c_os && bit_tick && !start_sync |=> !bit_tick);

  p_tail_r8: assert property (@(posedge clk) disable iff (!rst_n || hold)
    c_os && bit_tick && !smp_tick |-> $past(smp_tick));

  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n || hold)
    c_os && bypass && !bit_tick |-> smp_tick);

  p_vote_mid_r10: assert property (@(posedge clk) disable iff (!rst_n || hold)
    c_os && vote[2] |-> !bit_tick);
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n, hold, ovs_mode, start_sync;
  logic [15:0] div_val;
  logic [2:0]  bit_mod;
  logic [3:0]  smp_mod;
  logic        bit_tick, smp_tick;
  logic [2:0]  vote;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  frac_baud_gen #(.DIV_W(16)) i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .hold(hold), .ovs_mode(ovs_mode),
    .div_val(div_val), .bit_mod(bit_mod), .smp_mod(smp_mod),
    .start_sync(start_sync), .bit_tick(bit_tick), .smp_tick(smp_tick),
    .vote(vote));

  // {os, div[16], bit_mod[3], smp_mod[4], first bit length[12]}
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 16'd9,   3'd1, 4'd0,  12'd9},
    {1'b0, 16'd216, 3'd4, 4'd0,  12'd216},
    {1'b0, 16'd1,   3'd7, 4'd0,  12'd3},
    {1'b0, 16'd3,   3'd0, 4'd0,  12'd3},
    {1'b1, 16'd6,   3'd2, 4'd5,  12'd101},
    {1'b1, 16'd1,   3'd3, 4'd9,  12'd16},
    {1'b1, 16'd0,   3'd7, 4'd0,  12'd16},
    {1'b1, 16'd2,   3'd4, 4'd15, 12'd47}
  };

  function automatic int e8(int s, int i);
    return ((i + 1) * s) / 8 - (i * s) / 8;
  endfunction

  function automatic int e16(int s, int j);
    return ((j + 1) * s) / 16 - (j * s) / 16;
  endfunction

  function automatic int sper(int d, int sm, int j);
    return (d < 2) ? 1 : d + e16(sm, j);
  endfunction

  function automatic int blen(bit os, int d, int bm, int sm, int b);
    int acc = 0;
    if (!os) return ((d < 3) ? 3 : d) + e8(bm, b % 8);
    for (int j = 0; j < 16; j++) acc += sper(d, sm, j);
    return acc + e8(bm, b % 8);
  endfunction

  function automatic logic [4:0] eflags(bit os, int d, int bm, int sm, int b, int pos);
    logic [4:0] f = '0;
    int L = blen(os, d, bm, sm, b);
    int e = -1;
    f[4] = pos == L - 1;
    if (!os) begin
      f[0] = pos == L / 2 - 1;
      f[1] = pos == L / 2;
      f[2] = pos == L / 2 + 1;
    end else begin
      for (int j = 0; j < 16; j++) begin
        e += sper(d, sm, j);
        if (pos == e) begin
          f[3] = 1'b1;
          if (j == 6) f[0] = 1'b1;
          if (j == 7) f[1] = 1'b1;
          if (j == 8) f[2] = 1'b1;
        end
      end
    end
    return f;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic configure(input bit os, input int d, input int bm, input int sm);
    @(negedge clk);
    hold = 1'b1; ovs_mode = os; div_val = 16'(d); bit_mod = 3'(bm); smp_mod = 4'(sm);
    @(negedge clk);
    @(negedge clk);
    hold = 1'b0;
  endtask

  // Caller is at a negedge with inputs for the first sampled cycle already driven.
  task automatic run_bits(input bit os, input int d, input int bm, input int sm,
                          input int nbits, input int first_exp, input string req);
    int pos = 0, b = 0, n = 0, first = -1;
    while (b < nbits) begin
      #1;
      n++;
      check($sformatf("%s bit%0d pos%0d", req, b, pos),
            {bit_tick, smp_tick, vote}, eflags(os, d, bm, sm, b, pos));
      if (bit_tick && first < 0) first = n;
      if (pos == blen(os, d, bm, sm, b) - 1) begin
        b++;
        pos = 0;
      end else pos++;
      if (b < nbits) @(negedge clk);
    end
    check({req, " first bit length"}, first, first_exp);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; hold = 1'b1; ovs_mode = 1'b0; start_sync = 1'b0;
    div_val = 16'd5; bit_mod = 3'd0; smp_mod = 4'd0;
    repeat (3) @(negedge clk);
    #1 check("R1 reset outputs", {bit_tick, smp_tick, vote}, 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      #1 check("R1 quiet in hold", {bit_tick, smp_tick, vote}, 0);
    end

    for (int k = 0; k < 8; k++) begin
      automatic logic [35:0] v = VEC[k];
      configure(v[35], int'(v[34:19]), int'(v[18:16]), int'(v[15:12]));
      run_bits(v[35], int'(v[34:19]), int'(v[18:16]), int'(v[15:12]), 9, int'(v[11:0]),
               v[35] ? "R7 R8 R9 R10 table" : "R2 R5 R6 R11 table");
    end

    // R3: setting 4 alternates short and long bits
    configure(1'b0, 10, 4, 0);
    run_bits(1'b0, 10, 4, 0, 8, 10, "R3 even spread");

    // R1: settings changed outside hold are ignored
    configure(1'b0, 5, 3, 0);
    div_val = 16'd20; bit_mod = 3'd0; ovs_mode = 1'b1; smp_mod = 4'd7;
    run_bits(1'b0, 5, 3, 0, 9, 5, "R1 ignored change");

    // R4: restart partway through a character returns pattern to index 0
    configure(1'b0, 7, 6, 0);
    run_bits(1'b0, 7, 6, 0, 3, 7, "R4 before restart");
    @(negedge clk);
    @(negedge clk);
    start_sync = 1'b1;
    @(negedge clk);
    start_sync = 1'b0;
    run_bits(1'b0, 7, 6, 0, 4, 7, "R4 after restart");

    // R4 in oversampling mode
    configure(1'b1, 3, 5, 11);
    repeat (30) @(negedge clk);
    start_sync = 1'b1;
    @(negedge clk);
    start_sync = 1'b0;
    run_bits(1'b1, 3, 5, 11, 2, 59, "R4 oversampling restart");

    // R1: raising hold mid-run silences outputs
    @(negedge clk);
    hold = 1'b1;
    repeat (5) begin
      #1 check("R1 hold mid-run", {bit_tick, smp_tick, vote}, 0);
      @(negedge clk);
    end
    summary();
  end
endmodule